// File: doc/BRIEF.md
# In-Order Sequencer with Branch Delay Slot and Load Lock Board

This block steps a compact register-to-register instruction stream through a fetch stage and an execute stage. Loads and stores then pass to a separate memory stage. A jump never discards the instruction fetched behind it. That following instruction, the slot, always executes, and control moves to the jump target only after it. A load reserves its destination register on a lock board. Later instructions keep issuing until one of them reads a reserved register. Only that instruction waits, and it issues in the cycle after the data memory answers.

The block owns no storage for architectural state. It reads a register file through two combinational read ports and writes it through two write ports: one for ALU results and one for load returns. Instruction words arrive combinationally from the address it drives. Data memory is a single request port with a ready handshake of any latency. Two retire strobes report completed instructions with their addresses. One covers instructions that finish in execute, and the other covers memory operations as they complete. A checker can replay execution order from these strobes.

Top module: `dslot_seq`

## Requirements
- R1: While reset is low, no retire strobe, no memory request and no illegal flag is raised, and the fetch address is 0.
- R2: Opcode is bits [15:12]: 0 no-op, 1 LOAD (dest reg [11:8], data address [7:0]), 2 STORE (source reg [11:8], address [7:0]), 3 ADD (reg[11:8] += reg[7:4]), 4 SUB (reg[11:8] -= reg[7:4]), 5 ADDI (reg[11:8] += zero-extended [7:0]), 6 JUMP (target [11:0]). Other opcodes act as no-ops. ALU results wrap modulo 2^16 and appear on the ALU write port in the retire cycle.
- R3: Non-memory instructions that read no locked register retire one per clock, with no bubble at a jump.
- R4: The instruction after a jump always executes and retires before the jump target. The fetch address equals the target in the cycle after the jump retires.
- R5: A jump sitting in a delay slot raises the illegal flag in its retire cycle, behaves as a no-op, and execution continues at the next address.
- R6: An instruction that reads a register locked by an outstanding load (ADD/SUB both fields, ADDI [11:8], STORE [11:8]) issues no earlier than the cycle after that load's completion.
- R7: Instructions that read no locked register keep retiring while a load is outstanding.
- R8: One memory operation is outstanding at a time. Request, write flag, address and write data stay steady until ready. A later memory operation waits, and the request is low in the cycle after a completion.
- R9: In a load's ready cycle, the load write port writes the returned data to its destination and the memory retire strobe carries the load's address. A store completes in its ready cycle with the write flag high and the source register value from its issue cycle.
- R10: Execute-stage retires come in program order, and memory retires come in program order.
- R11: The two register write ports never target the same register in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 12 | Fetch address |
| imem_rdata | input | 16 | Instruction word at imem_addr |
| dmem_req | output | 1 | Memory operation outstanding |
| dmem_we | output | 1 | Outstanding operation is a store |
| dmem_addr | output | 8 | Data address |
| dmem_wdata | output | 16 | Store data |
| dmem_rdata | input | 16 | Load data, valid with ready |
| dmem_ready | input | 1 | Memory completes the operation this cycle |
| rf_ra_addr | output | 4 | Read port A index (bits [11:8]) |
| rf_ra_data | input | 16 | Read port A data |
| rf_rb_addr | output | 4 | Read port B index (bits [7:4]) |
| rf_rb_data | input | 16 | Read port B data |
| rf_wa_en | output | 1 | ALU write enable |
| rf_wa_addr | output | 4 | ALU write index |
| rf_wa_data | output | 16 | ALU write data |
| rf_wl_en | output | 1 | Load write enable |
| rf_wl_addr | output | 4 | Load write index |
| rf_wl_data | output | 16 | Load write data |
| ret_valid | output | 1 | Execute-stage instruction retires |
| ret_pc | output | 12 | Address of that instruction |
| mret_valid | output | 1 | Memory operation retires |
| mret_pc | output | 12 | Address of that operation |
| illegal_seq | output | 1 | Retiring jump was in a delay slot |

## Verification
A lock bit left set shows up as an execute retire that never arrives, or arrives late. The per-cycle comparison against the behavioural model catches it within a few cycles of the expected issue. A lock cleared too early lets a dependent ADD retire in the same cycle as its load, or write a stale sum. Either fault is caught at that retire. A slot-tracking error changes the retired address sequence at the first jump after it, and the illegal flag is compared on every execute retire.

// File: rtl/dslot_pkg.sv
// Shared encodings and control bundle for the delay-slot sequencer.
// Assumes 16-bit instruction words with the opcode in the top nibble.
package dslot_pkg;

    localparam int INSTR_W = 16;
    localparam int REGF_W  = 4;

    typedef enum logic [3:0] {
        OPC_NOP   = 4'd0,
        OPC_LOAD  = 4'd1,
        OPC_STORE = 4'd2,
        OPC_ADD   = 4'd3,
        OPC_SUB   = 4'd4,
        OPC_ADDI  = 4'd5,
        OPC_JUMP  = 4'd6
    } opcode_e;

    typedef enum logic [1:0] {
        FN_ADD,
        FN_SUB,
        FN_IMM
    } alu_fn_e;

    typedef struct packed {
        logic    is_load;
        logic    is_store;
        logic    is_alu;
        logic    is_jump;
        logic    use_a;
        logic    use_b;
        alu_fn_e fn;
    } ctrl_t;

endpackage

// File: rtl/dslot_decode.sv
// Instruction decoder: splits a word into control bits and fields.
// Purely combinational; unknown opcodes decode to an inert no-op.
module dslot_decode
    import dslot_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctrl,
    output logic [REGF_W-1:0]  fld_a,
    output logic [REGF_W-1:0]  fld_b,
    output logic [7:0]         imm8,
    output logic [11:0]        tgt12
);

    assign fld_a = instr[11:8];
    assign fld_b = instr[7:4];
    assign imm8  = instr[7:0];
    assign tgt12 = instr[11:0];

    // Map the opcode nibble to control bits and register read usage.
    always_comb begin
        ctrl = '{is_load: 1'b0, is_store: 1'b0, is_alu: 1'b0, is_jump: 1'b0,
                 use_a: 1'b0, use_b: 1'b0, fn: FN_ADD};
        case (instr[15:12])
            OPC_LOAD:  ctrl.is_load = 1'b1;
            OPC_STORE: begin
                ctrl.is_store = 1'b1;
                ctrl.use_a    = 1'b1;
            end
            OPC_ADD: begin
                ctrl.is_alu = 1'b1;
                ctrl.use_a  = 1'b1;
                ctrl.use_b  = 1'b1;
                ctrl.fn     = FN_ADD;
            end
            OPC_SUB: begin
                ctrl.is_alu = 1'b1;
                ctrl.use_a  = 1'b1;
                ctrl.use_b  = 1'b1;
                ctrl.fn     = FN_SUB;
            end
            OPC_ADDI: begin
                ctrl.is_alu = 1'b1;
                ctrl.use_a  = 1'b1;
                ctrl.fn     = FN_IMM;
            end
            OPC_JUMP:  ctrl.is_jump = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/dslot_lockboard.sv
// One lock bit per architectural register, set when a load issues and
// cleared when that load's data returns. Assumes set and clear never
// address the same bit in one cycle (the issue rule guarantees it).
module dslot_lockboard #(
    parameter int NREG = 16,
    localparam int RAW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_en,
    input  logic [RAW-1:0] set_idx,
    input  logic           clr_en,
    input  logic [RAW-1:0] clr_idx,
    input  logic [RAW-1:0] qa_idx,
    input  logic [RAW-1:0] qb_idx,
    output logic           hit_a,
    output logic           hit_b
);

    logic [NREG-1:0] lock_q;

    for (genvar g = 0; g < NREG; g++) begin : g_bit
        // Maintain the lock bit for register g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lock_q[g] <= 1'b0;
            end else if (clr_en && (clr_idx == RAW'(g))) begin
                lock_q[g] <= 1'b0;
            end else if (set_en && (set_idx == RAW'(g))) begin
                lock_q[g] <= 1'b1;
            end
        end
    end

    assign hit_a = lock_q[qa_idx];
    assign hit_b = lock_q[qb_idx];

endmodule

// File: rtl/dslot_memunit.sv
// Memory stage: holds one load or store until the data port answers.
// Assumes the issuer never starts an operation while busy is high.
module dslot_memunit #(
    parameter int DW  = 16,
    parameter int DAW = 8,
    parameter int PCW = 12,
    parameter int RAW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           issue_en,
    input  logic           issue_load,
    input  logic [DAW-1:0] issue_addr,
    input  logic [DW-1:0]  issue_data,
    input  logic [RAW-1:0] issue_reg,
    input  logic [PCW-1:0] issue_pc,
    input  logic           dmem_ready,
    output logic           busy,
    output logic           done,
    output logic           done_load,
    output logic [RAW-1:0] done_reg,
    output logic [PCW-1:0] done_pc,
    output logic           dmem_we,
    output logic [DAW-1:0] dmem_addr,
    output logic [DW-1:0]  dmem_wdata
);

    logic           load_q;
    logic [DAW-1:0] addr_q;
    logic [DW-1:0]  data_q;
    logic [RAW-1:0] reg_q;
    logic [PCW-1:0] pc_q;

    // Capture an issued operation and hold it until the ready cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            load_q <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            reg_q  <= '0;
            pc_q   <= '0;
        end else if (issue_en) begin
            busy   <= 1'b1;
            load_q <= issue_load;
            addr_q <= issue_addr;
            data_q <= issue_data;
            reg_q  <= issue_reg;
            pc_q   <= issue_pc;
        end else if (done) begin
            busy   <= 1'b0;
        end
    end

    assign done       = busy && dmem_ready;
    assign done_load  = load_q;
    assign done_reg   = reg_q;
    assign done_pc    = pc_q;
    assign dmem_we    = busy && !load_q;
    assign dmem_addr  = addr_q;
    assign dmem_wdata = data_q;

endmodule

// File: rtl/dslot_seq.sv
// Top of the sequencer: fetch register, execute/issue with delay-slot
// tracking, load lock board and a single-entry memory stage.
// Assumes instruction and register reads are combinational and that
// the register file writes at the clock edge.
module dslot_seq
    import dslot_pkg::*;
#(
    parameter int DW  = 16,
    parameter int PCW = 12,
    parameter int DAW = 8,
    localparam int NREG = 2 ** REGF_W,
    localparam int RAW  = REGF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PCW-1:0]     imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic               dmem_req,
    output logic               dmem_we,
    output logic [DAW-1:0]     dmem_addr,
    output logic [DW-1:0]      dmem_wdata,
    input  logic [DW-1:0]      dmem_rdata,
    input  logic               dmem_ready,
    output logic [RAW-1:0]     rf_ra_addr,
    input  logic [DW-1:0]      rf_ra_data,
    output logic [RAW-1:0]     rf_rb_addr,
    input  logic [DW-1:0]      rf_rb_data,
    output logic               rf_wa_en,
    output logic [RAW-1:0]     rf_wa_addr,
    output logic [DW-1:0]      rf_wa_data,
    output logic               rf_wl_en,
    output logic [RAW-1:0]     rf_wl_addr,
    output logic [DW-1:0]      rf_wl_data,
    output logic               ret_valid,
    output logic [PCW-1:0]     ret_pc,
    output logic               mret_valid,
    output logic [PCW-1:0]     mret_pc,
    output logic               illegal_seq
);

    logic [PCW-1:0]     pc;
    logic [INSTR_W-1:0] ir;
    logic [PCW-1:0]     ir_pc;
    logic               ir_valid;
    logic               in_slot;

    ctrl_t              ctrl;
    logic [RAW-1:0]     fld_a;
    logic [RAW-1:0]     fld_b;
    logic [7:0]         imm8;
    logic [11:0]        tgt12;
    logic [PCW-1:0]     jump_tgt;

    logic               hit_a;
    logic               hit_b;
    logic               mem_busy;
    logic               mem_done;
    logic               mem_done_load;
    logic [RAW-1:0]     mem_done_reg;
    logic [PCW-1:0]     mem_done_pc;

    logic               is_mem;
    logic               stall;
    logic               issue;
    logic               take_jump;
    logic [PCW-1:0]     pc_next;

    dslot_decode u_dec (
        .instr (ir),
        .ctrl  (ctrl),
        .fld_a (fld_a),
        .fld_b (fld_b),
        .imm8  (imm8),
        .tgt12 (tgt12)
    );

    assign jump_tgt = tgt12[PCW-1:0];
    assign is_mem   = ctrl.is_load || ctrl.is_store;

    dslot_lockboard #(.NREG(NREG)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (issue && ctrl.is_load),
        .set_idx (fld_a),
        .clr_en  (mem_done && mem_done_load),
        .clr_idx (mem_done_reg),
        .qa_idx  (fld_a),
        .qb_idx  (fld_b),
        .hit_a   (hit_a),
        .hit_b   (hit_b)
    );

    dslot_memunit #(.DW(DW), .DAW(DAW), .PCW(PCW), .RAW(RAW)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_en   (issue && is_mem),
        .issue_load (ctrl.is_load),
        .issue_addr (imm8[DAW-1:0]),
        .issue_data (rf_ra_data),
        .issue_reg  (fld_a),
        .issue_pc   (ir_pc),
        .dmem_ready (dmem_ready),
        .busy       (mem_busy),
        .done       (mem_done),
        .done_load  (mem_done_load),
        .done_reg   (mem_done_reg),
        .done_pc    (mem_done_pc),
        .dmem_we    (dmem_we),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata)
    );

    // Decide whether the held instruction may issue this cycle.
    always_comb begin
        stall = ir_valid && (((ctrl.use_a && hit_a) || (ctrl.use_b && hit_b))
                             || (is_mem && mem_busy));
        issue       = ir_valid && !stall;
        take_jump   = issue && ctrl.is_jump && !in_slot;
        illegal_seq = issue && ctrl.is_jump && in_slot;
        pc_next     = take_jump ? jump_tgt : pc + PCW'(1);
    end

    // Advance fetch and track whether the next issue sits in a slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            ir       <= '0;
            ir_pc    <= '0;
            ir_valid <= 1'b0;
            in_slot  <= 1'b0;
        end else begin
            if (!stall) begin
                pc       <= pc_next;
                ir       <= imem_rdata;
                ir_pc    <= pc;
                ir_valid <= 1'b1;
            end
            if (issue) begin
                in_slot <= take_jump;
            end
        end
    end

    // Compute the ALU result for add, subtract and add-immediate.
    always_comb begin
        case (ctrl.fn)
            FN_SUB:  rf_wa_data = rf_ra_data - rf_rb_data;
            FN_IMM:  rf_wa_data = rf_ra_data + DW'(imm8);
            default: rf_wa_data = rf_ra_data + rf_rb_data;
        endcase
    end

    assign imem_addr  = pc;
    assign rf_ra_addr = fld_a;
    assign rf_rb_addr = fld_b;
    assign rf_wa_en   = issue && ctrl.is_alu;
    assign rf_wa_addr = fld_a;
    assign rf_wl_en   = mem_done && mem_done_load;
    assign rf_wl_addr = mem_done_reg;
    assign rf_wl_data = dmem_rdata;
    assign dmem_req   = mem_busy;
    assign ret_valid  = issue && !is_mem;
    assign ret_pc     = ir_pc;
    assign mret_valid = mem_done;
    assign mret_pc    = mem_done_pc;

endmodule

// File: rtl/dslot_seq_chk.sv
// Property checker for dslot_seq, attached with the bind below.
// Observes ports plus the fetch register and jump decision.
module dslot_seq_chk #(
    parameter int DW  = 16,
    parameter int PCW = 12,
    parameter int DAW = 8,
    parameter int RAW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [PCW-1:0] imem_addr,
    input logic           dmem_req,
    input logic           dmem_we,
    input logic [DAW-1:0] dmem_addr,
    input logic [DW-1:0]  dmem_wdata,
    input logic           dmem_ready,
    input logic           rf_wa_en,
    input logic [RAW-1:0] rf_wa_addr,
    input logic           rf_wl_en,
    input logic [RAW-1:0] rf_wl_addr,
    input logic           ret_valid,
    input logic [PCW-1:0] ret_pc,
    input logic           mret_valid,
    input logic           illegal_seq,
    input logic           take_jump,
    input logic [PCW-1:0] jump_tgt,
    input logic           ir_valid,
    input logic [PCW-1:0] ir_pc
);

    // R4: fetch is at the target the cycle after a jump retires
    assert_jump_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_jump |=> imem_addr == $past(jump_tgt));

    // R4: the slot instruction is next in the execute register
    assert_slot_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_jump |=> ir_valid && (ir_pc == PCW'($past(ret_pc) + 1)));

    // R5: the illegal flag only accompanies a retiring untaken jump
    assert_illegal_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_seq |-> ret_valid && !take_jump);

    // R8: a waiting memory operation holds its request steady
    assert_mem_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_req && !dmem_ready |=> dmem_req && $stable(dmem_addr)
                                    && $stable(dmem_we) && $stable(dmem_wdata));

    // R8: no new request in the cycle after a completion
    assert_mem_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mret_valid |=> !dmem_req);

    // R9: load writes happen only when a load completes
    assert_load_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wl_en |-> mret_valid && dmem_req && !dmem_we);

    // R11: the two write ports never collide on one register
    assert_port_clash_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wa_en && rf_wl_en |-> rf_wa_addr != rf_wl_addr);

endmodule

bind dslot_seq dslot_seq_chk #(.DW(DW), .PCW(PCW), .DAW(DAW), .RAW(RAW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .imem_addr   (imem_addr),
    .dmem_req    (dmem_req),
    .dmem_we     (dmem_we),
    .dmem_addr   (dmem_addr),
    .dmem_wdata  (dmem_wdata),
    .dmem_ready  (dmem_ready),
    .rf_wa_en    (rf_wa_en),
    .rf_wa_addr  (rf_wa_addr),
    .rf_wl_en    (rf_wl_en),
    .rf_wl_addr  (rf_wl_addr),
    .ret_valid   (ret_valid),
    .ret_pc      (ret_pc),
    .mret_valid  (mret_valid),
    .illegal_seq (illegal_seq),
    .take_jump   (take_jump),
    .jump_tgt    (jump_tgt),
    .ir_valid    (ir_valid),
    .ir_pc       (ir_pc)
);

// File: tb/dslot_seq_bench.sv
`timescale 1ns/1ps
// Bench: behavioural instruction-level model feeding expected retire
// queues, compared against the design on every clock.
module dslot_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] imem_addr;
    logic [15:0] imem_rdata;
    logic        dmem_req, dmem_we;
    logic [7:0]  dmem_addr;
    logic [15:0] dmem_wdata, dmem_rdata;
    logic        dmem_ready = 1'b0;
    logic [3:0]  rf_ra_addr, rf_rb_addr, rf_wa_addr, rf_wl_addr;
    logic [15:0] rf_ra_data, rf_rb_data, rf_wa_data, rf_wl_data;
    logic        rf_wa_en, rf_wl_en;
    logic        ret_valid, mret_valid, illegal_seq;
    logic [11:0] ret_pc, mret_pc;

    logic [15:0] imem [0:4095];
    logic [15:0] regs [0:15];
    logic [15:0] dmem [0:255];

    int checks = 0;
    int fails  = 0;
    int mem_lat = 0;
    int lat_cnt = 0;

    int          e_pc[$];
    logic [15:0] e_wd[$];
    bit          e_hw[$];
    bit          e_ill[$];
    int          e_dep[$];
    int          m_pc[$];
    bit          m_ld[$];
    int          m_addr[$];
    logic [15:0] m_data[$];
    int          m_reg[$];
    int          seen[5];

    always #2 clk = ~clk;

    dslot_seq u_dslot_seq (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_req(dmem_req), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .dmem_ready(dmem_ready),
        .rf_ra_addr(rf_ra_addr), .rf_ra_data(rf_ra_data),
        .rf_rb_addr(rf_rb_addr), .rf_rb_data(rf_rb_data),
        .rf_wa_en(rf_wa_en), .rf_wa_addr(rf_wa_addr), .rf_wa_data(rf_wa_data),
        .rf_wl_en(rf_wl_en), .rf_wl_addr(rf_wl_addr), .rf_wl_data(rf_wl_data),
        .ret_valid(ret_valid), .ret_pc(ret_pc),
        .mret_valid(mret_valid), .mret_pc(mret_pc), .illegal_seq(illegal_seq)
    );

    assign imem_rdata = imem[imem_addr];
    assign rf_ra_data = regs[rf_ra_addr];
    assign rf_rb_data = regs[rf_rb_addr];
    assign dmem_rdata = dmem[dmem_addr];

    // Register file and data memory storage.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) regs[i] <= '0;
            for (int i = 0; i < 256; i++) dmem[i] <= 16'(i * 7 + 1);
        end else begin
            if (rf_wa_en) regs[rf_wa_addr] <= rf_wa_data;
            if (rf_wl_en) regs[rf_wl_addr] <= rf_wl_data;
            if (dmem_req && dmem_ready && dmem_we) dmem[dmem_addr] <= dmem_wdata;
        end
    end

    // Memory responder: ready after mem_lat waiting cycles.
    always @(posedge clk) begin
        #1;
        if (!dmem_req) begin
            lat_cnt = 0;
            dmem_ready = 1'b0;
        end else begin
            dmem_ready = (lat_cnt >= mem_lat);
            lat_cnt++;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] i_ld(int r, int a);   return {4'd1, 4'(r), 8'(a)}; endfunction
    function automatic logic [15:0] i_st(int r, int a);   return {4'd2, 4'(r), 8'(a)}; endfunction
    function automatic logic [15:0] i_add(int d, int s);  return {4'd3, 4'(d), 4'(s), 4'd0}; endfunction
    function automatic logic [15:0] i_sub(int d, int s);  return {4'd4, 4'(d), 4'(s), 4'd0}; endfunction
    function automatic logic [15:0] i_addi(int d, int k); return {4'd5, 4'(d), 8'(k)}; endfunction
    function automatic logic [15:0] i_jmp(int t);         return {4'd6, 12'(t)}; endfunction

    // Instruction-level model: fills the expected retire queues.
    task automatic build_model(int steps);
        logic [15:0] mr[16];
        logic [15:0] mm[256];
        int last_ld[16];
        int pc = 0, npc, tgt = 0, mcnt = 0, a, b, dep;
        bit br = 0, slot = 0, nslot;
        logic [15:0] ins, imm;
        e_pc.delete(); e_wd.delete(); e_hw.delete(); e_ill.delete(); e_dep.delete();
        m_pc.delete(); m_ld.delete(); m_addr.delete(); m_data.delete(); m_reg.delete();
        for (int i = 0; i < 16; i++) begin mr[i] = '0; last_ld[i] = -1; end
        for (int i = 0; i < 256; i++) mm[i] = 16'(i * 7 + 1);
        for (int s = 0; s < steps; s++) begin
            ins = imem[pc];
            a = int'(ins[11:8]);
            b = int'(ins[7:4]);
            imm = {8'd0, ins[7:0]};
            npc = br ? tgt : (pc + 1) % 4096;
            br = 0;
            nslot = 0;
            case (ins[15:12])
                4'd1: begin
                    m_pc.push_back(pc); m_ld.push_back(1); m_addr.push_back(int'(imm));
                    m_data.push_back(mm[imm]); m_reg.push_back(a);
                    mr[a] = mm[imm]; last_ld[a] = mcnt; mcnt++;
                end
                4'd2: begin
                    m_pc.push_back(pc); m_ld.push_back(0); m_addr.push_back(int'(imm));
                    m_data.push_back(mr[a]); m_reg.push_back(a);
                    mm[imm] = mr[a]; mcnt++;
                end
                4'd3, 4'd4, 4'd5: begin
                    dep = last_ld[a];
                    if (ins[15:12] != 4'd5 && last_ld[b] > dep) dep = last_ld[b];
                    if (ins[15:12] == 4'd3) mr[a] = mr[a] + mr[b];
                    else if (ins[15:12] == 4'd4) mr[a] = mr[a] - mr[b];
                    else mr[a] = mr[a] + imm;
                    e_pc.push_back(pc); e_wd.push_back(mr[a]); e_hw.push_back(1);
                    e_ill.push_back(0); e_dep.push_back(dep);
                end
                4'd6: begin
                    e_pc.push_back(pc); e_wd.push_back('0); e_hw.push_back(0);
                    e_ill.push_back(slot); e_dep.push_back(-1);
                    if (!slot) begin br = 1; tgt = int'(ins[11:0]); nslot = 1; end
                end
                default: begin
                    e_pc.push_back(pc); e_wd.push_back('0); e_hw.push_back(0);
                    e_ill.push_back(0); e_dep.push_back(-1);
                end
            endcase
            slot = nslot;
            pc = npc;
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 4096; i++) imem[i] = '0;
    endtask

    // Reset, then compare the design against the model every clock.
    task automatic run(int lat, int steps, bit every, output int ahead);
        int cyc = 0, mret_cnt = 0, nseen = 0, p, dep;
        bit started = 0, prev_m = 0, ill;
        mem_lat = lat;
        rst_n = 1'b0;
        ahead = 0;
        build_model(steps);
        repeat (3) begin
            @(negedge clk);
            chk(!ret_valid && !mret_valid && !dmem_req && !illegal_seq && imem_addr == 0,
                "R1 reset state", int'(ret_valid | mret_valid | dmem_req), 0);
        end
        rst_n = 1'b1;
        while (e_pc.size() + m_pc.size() > 0) begin
            @(negedge clk);
            cyc++;
            if (cyc > 3000) begin
                chk(0, "watchdog", cyc, 3000);
                break;
            end
            if (prev_m) chk(!dmem_req, "R8 gap after completion", int'(dmem_req), 0);
            if (ret_valid) begin
                if (e_pc.size() == 0) begin
                    chk(0, "R10 extra execute retire", int'(ret_pc), -1);
                end else begin
                    p = e_pc.pop_front();
                    ill = e_ill.pop_front();
                    dep = e_dep.pop_front();
                    if (nseen < 5) begin seen[nseen] = int'(ret_pc); nseen++; end
                    chk(int'(ret_pc) == p, "R10 execute order", int'(ret_pc), p);
                    chk(illegal_seq == ill, "R5 illegal flag", int'(illegal_seq), int'(ill));
                    chk(dep < mret_cnt, "R6 lock wait", mret_cnt, dep + 1);
                    if (e_hw.pop_front()) begin
                        chk(rf_wa_en && rf_wa_data == e_wd[0], "R2 alu result",
                            int'(rf_wa_data), int'(e_wd[0]));
                    end else begin
                        chk(!rf_wa_en, "R2 no write", int'(rf_wa_en), 0);
                    end
                    void'(e_wd.pop_front());
                    if (dmem_req && !dmem_we) ahead++;
                end
                started = 1;
            end else if (every && started && e_pc.size() > 0) begin
                chk(0, "R3 one per clock", 0, 1);
            end
            prev_m = mret_valid;
            if (mret_valid) begin
                if (m_pc.size() == 0) begin
                    chk(0, "R10 extra memory retire", int'(mret_pc), -1);
                end else begin
                    p = m_pc.pop_front();
                    chk(int'(mret_pc) == p, "R10 memory order", int'(mret_pc), p);
                    chk(int'(dmem_addr) == m_addr[0], "R8 address", int'(dmem_addr), m_addr[0]);
                    if (m_ld[0]) begin
                        chk(!dmem_we && rf_wl_en && int'(rf_wl_addr) == m_reg[0]
                            && rf_wl_data == m_data[0], "R9 load return",
                            int'(rf_wl_data), int'(m_data[0]));
                    end else begin
                        chk(dmem_we && !rf_wl_en && dmem_wdata == m_data[0], "R9 store data",
                            int'(dmem_wdata), int'(m_data[0]));
                    end
                    chk(!(rf_wa_en && rf_wl_en && rf_wa_addr == rf_wl_addr),
                        "R11 port clash", int'(rf_wa_addr), int'(rf_wl_addr));
                    void'(m_ld.pop_front()); void'(m_addr.pop_front());
                    void'(m_data.pop_front()); void'(m_reg.pop_front());
                    mret_cnt++;
                end
            end
        end
        @(negedge clk);
    endtask

    initial begin
        int ahead;
        // Test 1: ALU only, delay slots, jump in a slot (R2 R3 R4 R5)
        clear_prog();
        imem[0] = i_addi(1, 3);
        imem[1] = i_jmp(5);
        imem[2] = i_addi(2, 4);
        imem[3] = i_addi(3, 100);
        imem[4] = i_addi(3, 100);
        imem[5] = i_add(2, 1);
        imem[6] = i_sub(1, 2);
        imem[7] = i_jmp(9);
        imem[8] = i_jmp(12);
        imem[9] = i_addi(4, 1);
        imem[10] = i_jmp(10);
        run(0, 14, 1, ahead);
        chk(seen[0] == 0 && seen[1] == 1 && seen[2] == 2 && seen[3] == 5 && seen[4] == 6,
            "R4 slot then target", seen[3], 5);

        // Test 2: load lock with independent run-ahead (R6 R7 R9)
        clear_prog();
        imem[0] = i_ld(1, 10);
        imem[1] = i_addi(2, 2);
        imem[2] = i_addi(3, 3);
        imem[3] = i_add(4, 1);
        imem[4] = i_st(4, 20);
        imem[5] = i_ld(5, 20);
        imem[6] = i_add(5, 2);
        imem[7] = i_sub(2, 3);
        imem[8] = i_jmp(8);
        run(5, 12, 0, ahead);
        chk(ahead == 2, "R7 run ahead of load", ahead, 2);

        // Test 3: back-to-back memory ops, load in a slot (R8 R9 R10)
        clear_prog();
        imem[0] = i_addi(1, 9);
        imem[1] = i_st(1, 3);
        imem[2] = i_ld(2, 3);
        imem[3] = i_ld(3, 4);
        imem[4] = i_jmp(8);
        imem[5] = i_ld(6, 5);
        imem[6] = i_addi(7, 1);
        imem[8] = i_add(2, 3);
        imem[9] = i_addi(0, 1);
        imem[10] = i_jmp(10);
        run(0, 12, 0, ahead);
        run(3, 12, 0, ahead);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule